// File: doc/BRIEF.md
# Four-Channel Shadowed PWM Controller

This block is a memory-mapped pulse-width modulator with four independent outputs. Each channel counts input clock ticks through a programmable period. Its output is active during the first part of the period, for a programmable number of ticks, and inactive for the rest. Every channel has its own polarity bit and a mode field that turns modulation on or off.

All channel settings are double-buffered. Software writes the staged copies of the channel registers and of the enable bits in the global register. Nothing changes at the outputs until software sets the commit bit in the global register. The commit is then taken up by every channel. A channel that is running applies the new settings at the end of its current period, so no pulse is ever cut short. A channel that is stopped applies them on the next clock.

The register bus is a plain 32-bit word interface. A write takes effect on the clock edge that samples it. Read data appears one clock after the read strobe.

Top module: `pwm_quad_shadow`

## Requirements
- R1: After reset every output is low. Each channel control register reads 0x101 (mode 1, flag bit 8 set). Range, phase, duty and the global register read 0.
- R2: The register map is as follows. Global is at byte address 0x000. Channel x has control at 0x014+0x10·x, range at 0x018+0x10·x, phase at 0x01C+0x10·x and duty at 0x020+0x10·x. Range, phase and duty hold all 32 bits. Control keeps bits [1:0], 3 and 8, and its other bits read 0. Global keeps bits [3:0], and its other bits read 0. A read returns data one cycle after `bus_re`. Unmapped addresses read 0 and ignore writes.
- R3: Writes to staged registers, including the global enable bits, leave the outputs unchanged until a commit.
- R4: A channel in mode 1 runs a counter 0..range−1 that restarts from 0 when committed from a stopped state. Before polarity is applied, the output is high while the count is below duty. The first tick after activation is high if duty > 0.
- R5: When duty ≥ range, the output stays active for the whole period. When duty = 0, it stays inactive.
- R6: Control bit 3 set inverts the channel output.
- R7: A channel whose enable bit (global bit x) is 0, or whose mode is not 1, drives its idle level. The idle level equals control bit 3.
- R8: Writing global bit 31 as 1 commits the staged values of all four channels. Bit 31 always reads 0.
- R9: A running channel loads committed values only at its period wrap, so the current period completes with the old settings. A stopped channel loads them on the second clock edge after the commit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the PWM tick |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | AW (12) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pwm_out | output | 4 | Channel outputs, bit x is channel x |

## Verification
A live register that holds a stale or wrong value shows up at the ports within one period: the next high or low run has the wrong length. A missed pending flag leaves the old waveform running past its wrap. A counter that escapes its range, or one left non-zero while idle, makes the first pulse after re-activation the wrong width in the first few cycles. The bench therefore compares every output cycle across the commit boundary, not only averages.

// File: rtl/pwm_quad_shadow.sv
module pwm_quad_shadow #(
  parameter int AW = 12,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [3:0]    pwm_out
);
  localparam int NCH = 4;
  localparam logic [AW-1:0] CH_BASE = AW'('h014);
  localparam logic [AW-1:0] CH_LAST = AW'('h050);

  logic sel_glob, sel_ch;
  logic [1:0] ch_idx, reg_idx;

  assign sel_glob = bus_addr == '0;
  assign sel_ch   = bus_addr >= CH_BASE && bus_addr <= CH_LAST && bus_addr[1:0] == 2'b00;
  assign ch_idx   = 2'((bus_addr - CH_BASE) >> 4);
  assign reg_idx  = 2'((bus_addr - CH_BASE) >> 2);

  logic [NCH-1:0]          stg_en, stg_inv, stg_aux;
  logic [NCH-1:0][1:0]     stg_mode;
  logic [NCH-1:0][CW-1:0]  stg_range, stg_phase, stg_duty;

  logic [NCH-1:0]          live_en, live_inv;
  logic [NCH-1:0][1:0]     live_mode;
  logic [NCH-1:0][CW-1:0]  live_range, live_duty, cnt;

  logic [NCH-1:0]          pend, act, wrap, load;
  logic                    commit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_q  <= 1'b0;
      stg_en    <= '0;
      stg_inv   <= '0;
      stg_aux   <= '1;
      stg_mode  <= {NCH{2'd1}};
      stg_range <= '0;
      stg_phase <= '0;
      stg_duty  <= '0;
    end else begin
      commit_q <= bus_we && sel_glob && bus_wdata[31];
      if (bus_we && sel_glob) stg_en <= bus_wdata[NCH-1:0];
      if (bus_we && sel_ch) begin
        case (reg_idx)
          2'd0: begin
            stg_mode[ch_idx] <= bus_wdata[1:0];
            stg_inv[ch_idx]  <= bus_wdata[3];
            stg_aux[ch_idx]  <= bus_wdata[8];
          end
          2'd1: stg_range[ch_idx] <= bus_wdata[CW-1:0];
          2'd2: stg_phase[ch_idx] <= bus_wdata[CW-1:0];
          default: stg_duty[ch_idx] <= bus_wdata[CW-1:0];
        endcase
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      act[i]     = live_en[i] && live_mode[i] == 2'd1;
      wrap[i]    = act[i] && (live_range[i] == '0 || cnt[i] >= live_range[i] - CW'(1));
      load[i]    = (pend[i] || commit_q) && (wrap[i] || !act[i]);
      pwm_out[i] = act[i] ? ((cnt[i] < live_duty[i]) ^ live_inv[i]) : live_inv[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_en    <= '0;
      live_inv   <= '0;
      live_mode  <= {NCH{2'd1}};
      live_range <= '0;
      live_duty  <= '0;
      cnt        <= '0;
      pend       <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (load[i]) begin
          live_en[i]    <= stg_en[i];
          live_inv[i]   <= stg_inv[i];
          live_mode[i]  <= stg_mode[i];
          live_range[i] <= stg_range[i];
          live_duty[i]  <= stg_duty[i];
          cnt[i]        <= '0;
          pend[i]       <= 1'b0;
        end else begin
          if (commit_q) pend[i] <= 1'b1;
          cnt[i] <= (!act[i] || wrap[i]) ? '0 : cnt[i] + CW'(1);
        end
      end
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_glob) begin
      rd_mux[NCH-1:0] = stg_en;
    end else if (sel_ch) begin
      case (reg_idx)
        2'd0: begin
          rd_mux[1:0] = stg_mode[ch_idx];
          rd_mux[3]   = stg_inv[ch_idx];
          rd_mux[8]   = stg_aux[ch_idx];
        end
        2'd1: rd_mux = 32'(stg_range[ch_idx]);
        2'd2: rd_mux = 32'(stg_phase[ch_idx]);
        default: rd_mux = 32'(stg_duty[ch_idx]);
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/pwm_quad_shadow_chk.sv
module pwm_quad_shadow_chk #(
  parameter int AW = 12,
  parameter int CW = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_re,
  input logic [AW-1:0]       bus_addr,
  input logic [31:0]         bus_rdata,
  input logic                commit_q,
  input logic [3:0]          pend,
  input logic [3:0]          act,
  input logic [3:0]          wrap,
  input logic [3:0]          load,
  input logic [3:0][CW-1:0]  cnt,
  input logic [3:0][CW-1:0]  live_range,
  input logic [3:0][CW-1:0]  live_duty
);
  a_r8_commit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == '0) |=> !bus_rdata[31]);

  for (genvar i = 0; i < 4; i++) begin : g_chk
    a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (act[i] && live_range[i] != '0) |-> cnt[i] < live_range[i]);
    a_r7_idle_cnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !act[i] |-> cnt[i] == '0);
    a_r3_live_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit_q && !pend[i]) |=> $stable(live_duty[i]));
    a_r8_pend_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_q && !load[i]) |=> pend[i]);
    a_r9_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(live_range[i]) |-> $past(wrap[i] || !act[i]));
  end
endmodule

bind pwm_quad_shadow pwm_quad_shadow_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/pwm_quad_shadow_tb.sv
module pwm_quad_shadow_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0] pwm_out;

  int total = 0, bad = 0;

  logic [3:0]  pw_v[$];
  string       pw_tag[$];
  logic [31:0] rd_v[$];
  string       rd_tag[$];

  int cr[4], cd[4];
  bit ci[4], co[4];

  always #5 clk = ~clk;

  pwm_quad_shadow u_dut (.clk, .rst_n, .bus_we, .bus_re, .bus_addr,
                         .bus_wdata, .bus_rdata, .pwm_out);

  always @(negedge clk) begin
    if (rd_v.size() > 0) begin
      logic [31:0] e; string t;
      e = rd_v.pop_front(); t = rd_tag.pop_front();
      total++;
      if (bus_rdata !== e) begin
        bad++;
        $display("FAIL %s rdata actual=%h expected=%h", t, bus_rdata, e);
      end
    end
    if (pw_v.size() > 0) begin
      logic [3:0] e; string t;
      e = pw_v.pop_front(); t = pw_tag.pop_front();
      total++;
      if (pwm_out !== e) begin
        bad++;
        $display("FAIL %s pwm_out actual=%b expected=%b", t, pwm_out, e);
      end
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] e, string t);
    bus_re = 1'b1; bus_addr = a;
    rd_v.push_back(e); rd_tag.push_back(t);
    @(negedge clk); #1;
    bus_re = 1'b0;
  endtask

  task automatic drain();
    while (pw_v.size() > 0 || rd_v.size() > 0) begin @(negedge clk); #1; end
  endtask

  task automatic do_reset();
    bus_we = 1'b0; bus_re = 1'b0;
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    for (int c = 0; c < 4; c++) begin cr[c] = 0; cd[c] = 0; ci[c] = 0; co[c] = 0; end
  endtask

  function automatic logic ch_exp(int c, int k);
    int p;
    if (!co[c]) return ci[c];
    p = (cr[c] == 0) ? 0 : k % cr[c];
    return (p < cd[c]) ^ ci[c];
  endfunction

  task automatic push_cfg(int k0, int n, string t);
    for (int k = k0; k < k0 + n; k++) begin
      logic [3:0] v;
      for (int c = 0; c < 4; c++) v[c] = ch_exp(c, k);
      pw_v.push_back(v); pw_tag.push_back(t);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    do_reset();

    // R1: reset state
    push_cfg(0, 3, "R1");
    drain();
    rd(12'h014, 32'h101, "R1"); rd(12'h024, 32'h101, "R1");
    rd(12'h034, 32'h101, "R1"); rd(12'h044, 32'h101, "R1");
    rd(12'h018, 32'h0, "R1");   rd(12'h000, 32'h0, "R1");
    drain();

    // R2: register map and field storage
    wr(12'h028, 32'hDEADBEEF); rd(12'h028, 32'hDEADBEEF, "R2");
    wr(12'h03C, 32'h12345678); rd(12'h03C, 32'h12345678, "R2");
    wr(12'h044, 32'hFFFFFFFF); rd(12'h044, 32'h0000010B, "R2");
    wr(12'h000, 32'h0000FFF5); rd(12'h000, 32'h00000005, "R2");
    rd(12'h004, 32'h0, "R2");
    wr(12'h054, 32'h1);        rd(12'h054, 32'h0, "R2");
    drain();

    // R3 then R4: staged values idle until commit, then waveform
    do_reset();
    wr(12'h018, 10); wr(12'h020, 3);
    wr(12'h028, 5);  wr(12'h030, 2);
    wr(12'h000, 32'h3);
    push_cfg(0, 15, "R3");
    drain();
    wr(12'h000, 32'h80000003);
    cr[0] = 10; cd[0] = 3; co[0] = 1;
    cr[1] = 5;  cd[1] = 2; co[1] = 1;
    push_cfg(0, 30, "R4");
    drain();
    rd(12'h000, 32'h3, "R8");
    drain();

    // R9: mid-period commit waits for wrap
    do_reset();
    wr(12'h018, 10); wr(12'h020, 3);
    wr(12'h000, 32'h80000001);
    cr[0] = 10; cd[0] = 3; co[0] = 1;
    push_cfg(0, 10, "R9");
    cd[0] = 7;
    push_cfg(0, 20, "R9");
    idle(2);
    wr(12'h020, 7);
    wr(12'h000, 32'h80000001);
    drain();

    // R5 and R6: duty limits and polarity
    do_reset();
    wr(12'h018, 4); wr(12'h020, 4);
    wr(12'h028, 4); wr(12'h030, 0);
    wr(12'h034, 32'h109); wr(12'h038, 6); wr(12'h040, 2);
    wr(12'h044, 32'h109); wr(12'h048, 6); wr(12'h050, 9);
    wr(12'h000, 32'h8000000F);
    cr[0] = 4; cd[0] = 4; co[0] = 1;
    cr[1] = 4; cd[1] = 0; co[1] = 1;
    cr[2] = 6; cd[2] = 2; co[2] = 1; ci[2] = 1;
    cr[3] = 6; cd[3] = 9; co[3] = 1; ci[3] = 1;
    push_cfg(0, 20, "R5,R6");
    drain();

    // R7: mode 0, disabled, and mode 2 channels drive idle level
    do_reset();
    wr(12'h014, 32'h108);
    wr(12'h024, 32'h109); wr(12'h028, 4); wr(12'h030, 2);
    wr(12'h034, 32'h102); wr(12'h038, 4); wr(12'h040, 2);
    wr(12'h048, 3); wr(12'h050, 1);
    wr(12'h000, 32'h8000000D);
    ci[0] = 1; ci[1] = 1;
    cr[3] = 3; cd[3] = 1; co[3] = 1;
    push_cfg(0, 12, "R7");
    drain();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule